// File: doc/BRIEF.md
# Display Panel Power Sequencer

This block brings the four stages of a display path up and down in a safe order: the pixel clock, the timing synchronization, the panel DISP line and the backlight PWM. Software sets stage enables through a write-one-to-set register and clears them through a separate write-one-to-clear register. A status register shows which stages are really running, so the driver can poll each stage before it moves on to the next.

The block enforces the dependency chain in hardware. Synchronization may only start while the clock runs, and DISP may only start while synchronization runs. DISP is raised only after a programmable guard time, counted in start-of-frame pulses from the timing generator. When a stage is disabled, every stage above it in the chain is disabled with it, and each stage reports off only after the stages that depend on it have stopped. Each transition takes a fixed number of cycles, or a number of frames set by the guard register, so it ends well within any software poll timeout.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset all stage enables and all status bits are 0, and the guard register reads 1.
- R2: Register map: address 0 sets enables (writing 1 to a bit sets it) and address 1 clears them (writing 1 to a bit clears it). Both addresses read back the enables. Address 2 reads status and ignores writes. Address 3 holds the guard count. Bit 0 is the clock, bit 1 sync, bit 2 DISP and bit 3 PWM. Zero bits written to address 0 or 1 change nothing.
- R3: The clock, sync and PWM status bits rise exactly STAGE_DLY cycles (default 4) after the edge that sets their enable, and fall STAGE_DLY cycles after the edge that clears it, unless they are held by R7 or R8.
- R4: A set request for sync is dropped while the clock enable or clock status is 0. A set request for DISP is dropped while the sync enable or sync status is 0. A dropped request leaves both the enable and the status at 0.
- R5: With guard value G > 0, DISP status rises one cycle after the edge that samples the G-th start-of-frame pulse seen after the DISP enable was set. With G = 0 it rises one cycle after that enable edge.
- R6: The guard register at address 3 is DW bits wide and reads back the value last written.
- R7: Clearing sync also clears the DISP enable. DISP status falls first, and sync status falls STAGE_DLY cycles after DISP status falls.
- R8: Clearing the clock also clears the sync and DISP enables. Clock status falls STAGE_DLY cycles after sync status reaches 0.
- R9: DISP status falls DISP_OFF_DLY cycles (default 2) after the edge that clears its enable.
- R10: PWM has no dependency: it can be enabled and disabled whatever state the other stages are in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational on reg_addr |
| frame_start | input | 1 | One-cycle start-of-frame pulse from the timing generator |
| pclk_run_o | output | 1 | Pixel clock stage running |
| sync_run_o | output | 1 | Synchronization stage running |
| disp_o | output | 1 | Panel DISP line |
| pwm_run_o | output | 1 | Backlight PWM stage running |

## Verification
The bench first brings stages up in the legal order and checks the exact cycle on which each status edge appears. This separates a correct settle count from a count that is off by one. It then issues enable requests out of order: sync with the clock off, and DISP with sync off. These must leave the enables untouched, while a PWM request made at the same time still goes through. The guard path is driven with G values of 0, 1 and 2 and with frame pulses spread apart, which tells counting frames apart from counting cycles. Finally the bench clears sync and then the clock while the stages above them are still on. This shows whether the forced shutdown of dependent stages happens, and whether the status bits fall in top-down order.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  localparam int NSTAGE = 4;

  localparam int STG_CLK  = 0;
  localparam int STG_SYNC = 1;
  localparam int STG_DISP = 2;
  localparam int STG_PWM  = 3;

  typedef logic [NSTAGE-1:0] stage_vec_t;

  typedef enum logic [1:0] {
    ADDR_SET   = 2'd0,
    ADDR_CLR   = 2'd1,
    ADDR_STAT  = 2'd2,
    ADDR_GUARD = 2'd3
  } reg_addr_e;

  // Drop set requests whose prerequisite stage is not fully up.
  function automatic stage_vec_t filter_set(stage_vec_t req, stage_vec_t en, stage_vec_t sts);
    stage_vec_t ok;
    ok           = req;
    ok[STG_SYNC] = req[STG_SYNC] & en[STG_CLK]  & sts[STG_CLK];
    ok[STG_DISP] = req[STG_DISP] & en[STG_SYNC] & sts[STG_SYNC];
    return ok;
  endfunction

  // Extend a clear request to every stage that depends on a cleared one.
  function automatic stage_vec_t spread_clear(stage_vec_t req);
    stage_vec_t m;
    m           = req;
    m[STG_SYNC] = req[STG_SYNC] | req[STG_CLK];
    m[STG_DISP] = req[STG_DISP] | req[STG_SYNC] | req[STG_CLK];
    return m;
  endfunction

  // Turn-on prerequisite of each stage.
  function automatic stage_vec_t on_permit(stage_vec_t sts);
    stage_vec_t p;
    p           = '1;
    p[STG_SYNC] = sts[STG_CLK];
    p[STG_DISP] = sts[STG_SYNC];
    return p;
  endfunction

  // A stage may report off only when its dependents are off.
  function automatic stage_vec_t off_permit(stage_vec_t sts);
    stage_vec_t p;
    p          = '1;
    p[STG_CLK]  = ~sts[STG_SYNC];
    p[STG_SYNC] = ~sts[STG_DISP];
    return p;
  endfunction

endpackage

// File: rtl/pwrseq_regs.sv
module pwrseq_regs
  import pwrseq_pkg::*;
#(
  parameter int DW        = 8,
  parameter int GUARD_RST = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  stage_vec_t    sts_i,
  output stage_vec_t    en_o,
  output logic [DW-1:0] guard_o,
  output logic [DW-1:0] reg_rdata
);

  stage_vec_t    en_q;
  logic [DW-1:0] guard_q;
  stage_vec_t    wr_mask;
  stage_vec_t    set_ok;
  stage_vec_t    clr_all;

  assign wr_mask = reg_wdata[NSTAGE-1:0];
  assign set_ok  = filter_set(wr_mask, en_q, sts_i);
  assign clr_all = spread_clear(wr_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      guard_q <= DW'(GUARD_RST);
    end else if (reg_wr) begin
      case (reg_addr_e'(reg_addr))
        ADDR_SET:   en_q    <= en_q | set_ok;
        ADDR_CLR:   en_q    <= en_q & ~clr_all;
        ADDR_GUARD: guard_q <= reg_wdata;
        default:    ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr_e'(reg_addr))
      ADDR_SET, ADDR_CLR: reg_rdata[NSTAGE-1:0] = en_q;
      ADDR_STAT:          reg_rdata[NSTAGE-1:0] = sts_i;
      default:            reg_rdata = guard_q;
    endcase
  end

  assign en_o    = en_q;
  assign guard_o = guard_q;

endmodule

// File: rtl/pwrseq_stage.sv
module pwrseq_stage #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             on_ok_i,
  input  logic             off_ok_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] target_i,
  output logic             sts_o
);

  logic             sts_q;
  logic [CNT_W-1:0] cnt_q;
  logic             want_on;
  logic             want_off;
  logic             pending;
  logic             reached;

  assign want_on  = en_i & ~sts_q & on_ok_i;
  assign want_off = ~en_i & sts_q & off_ok_i;
  assign pending  = want_on | want_off;
  assign reached  = (cnt_q == target_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= 1'b0;
      cnt_q <= '0;
    end else if (!pending) begin
      cnt_q <= '0;
    end else if (reached) begin
      sts_q <= ~sts_q;
      cnt_q <= '0;
    end else if (inc_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sts_o = sts_q;

endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import pwrseq_pkg::*;
#(
  parameter int DW           = 8,
  parameter int GUARD_RST    = 1,
  parameter int STAGE_DLY    = 4,
  parameter int DISP_OFF_DLY = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          frame_start,
  output logic          pclk_run_o,
  output logic          sync_run_o,
  output logic          disp_o,
  output logic          pwm_run_o
);

  localparam int MAX_DLY = (STAGE_DLY > DISP_OFF_DLY) ? STAGE_DLY : DISP_OFF_DLY;
  localparam int DLY_W   = $clog2(MAX_DLY + 1);
  localparam int CNT_W   = (DW > DLY_W) ? DW : DLY_W;

  stage_vec_t    en_q;
  stage_vec_t    sts_q;
  stage_vec_t    on_ok;
  stage_vec_t    off_ok;
  logic [DW-1:0] guard_q;

  pwrseq_regs #(
    .DW        (DW),
    .GUARD_RST (GUARD_RST)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .sts_i     (sts_q),
    .en_o      (en_q),
    .guard_o   (guard_q),
    .reg_rdata (reg_rdata)
  );

  assign on_ok  = on_permit(sts_q);
  assign off_ok = off_permit(sts_q);

  for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
    localparam int DLY_I = (i == STG_DISP) ? DISP_OFF_DLY : STAGE_DLY;
    logic             inc;
    logic [CNT_W-1:0] target;

    if (i == STG_DISP) begin : g_frames
      // Turning on counts frames against the guard value; turning off counts cycles.
      assign inc    = sts_q[i] ? 1'b1 : frame_start;
      assign target = sts_q[i] ? CNT_W'(DLY_I - 1) : CNT_W'(guard_q);
    end else begin : g_cycles
      assign inc    = 1'b1;
      assign target = CNT_W'(DLY_I - 1);
    end

    pwrseq_stage #(
      .CNT_W (CNT_W)
    ) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (en_q[i]),
      .on_ok_i  (on_ok[i]),
      .off_ok_i (off_ok[i]),
      .inc_i    (inc),
      .target_i (target),
      .sts_o    (sts_q[i])
    );
  end

  assign pclk_run_o = sts_q[STG_CLK];
  assign sync_run_o = sts_q[STG_SYNC];
  assign disp_o     = sts_q[STG_DISP];
  assign pwm_run_o  = sts_q[STG_PWM];

endmodule

// File: rtl/panel_pwr_seq_chk.sv
module panel_pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_stat,
  input logic       wr_clr_sync,
  input logic [3:0] en,
  input logic [3:0] sts
);

  // R8
  sync_needs_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts[1] |-> sts[0]);

  // R7
  disp_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts[2] |-> sts[1]);

  // R4
  sync_set_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en[1]) |-> $past(en[0] & sts[0]));

  // R4
  disp_set_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en[2]) |-> $past(en[1] & sts[1]));

  // R2
  status_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> $stable(en));

  // R7
  sync_clear_drops_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr_sync |=> !en[2]);

  // R5
  disp_rise_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[2]) |-> $past(en[2]));

  // R3
  clk_fall_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts[0]) |-> $past(!en[0]));

endmodule

bind panel_pwr_seq panel_pwr_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_stat     (reg_wr && reg_addr == 2'd2),
  .wr_clr_sync (reg_wr && reg_addr == 2'd1 && reg_wdata[1]),
  .en          (en_q),
  .sts         (sts_q)
);

// File: tb/tb_panel_pwr_seq.sv
`timescale 1ns/1ps
module tb_panel_pwr_seq;

  localparam int DLY  = 4;
  localparam int DOFF = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       frame_start = 1'b0;
  logic       pclk_run_o, sync_run_o, disp_o, pwm_run_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  panel_pwr_seq dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .frame_start (frame_start),
    .pclk_run_o  (pclk_run_o),
    .sync_run_o  (sync_run_o),
    .disp_o      (disp_o),
    .pwm_run_o   (pwm_run_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_wdata = 8'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a; #0.5;
    v = reg_rdata;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(posedge clk); #1;
    frame_start = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); check("R1", "enables after reset", v, 0);
    rd(2'd2, v); check("R1", "status after reset", v, 0);
    rd(2'd3, v); check("R1", "guard after reset", v, 1);
    check("R1", "pins after reset", {pwm_run_o, disp_o, sync_run_o, pclk_run_o}, 0);
  endtask

  task automatic t_dependency();
    logic [7:0] v;
    wr(2'd0, 8'h02);
    rd(2'd0, v); check("R4", "sync set without clock", v, 0);
    wr(2'd0, 8'h04);
    rd(2'd0, v); check("R4", "disp set without sync", v, 0);
    tick(8);
    rd(2'd2, v); check("R4", "status after dropped sets", v, 0);
  endtask

  task automatic t_pwm();
    logic [7:0] v;
    wr(2'd0, 8'h08);
    rd(2'd0, v); check("R10", "pwm enable alone", v, 8'h08);
    tick(DLY - 1); check("R3", "pwm before settle", pwm_run_o, 0);
    tick(1);       check("R3", "pwm at settle", pwm_run_o, 1);
    wr(2'd1, 8'h08);
    tick(DLY - 1); check("R10", "pwm before off", pwm_run_o, 1);
    tick(1);       check("R10", "pwm off", pwm_run_o, 0);
  endtask

  task automatic t_clock_sync();
    logic [7:0] v;
    wr(2'd0, 8'h01);
    tick(DLY - 1); check("R3", "clock before settle", pclk_run_o, 0);
    tick(1);       check("R3", "clock at settle", pclk_run_o, 1);
    wr(2'd0, 8'h04);
    rd(2'd0, v); check("R4", "disp set with sync off", v, 8'h01);
    wr(2'd0, 8'h02);
    tick(DLY - 1); check("R3", "sync before settle", sync_run_o, 0);
    tick(1);       check("R3", "sync at settle", sync_run_o, 1);
  endtask

  task automatic t_zero_writes();
    logic [7:0] v;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h0F);
    rd(2'd0, v); check("R2", "zero and status writes keep enables", v, 8'h03);
    tick(DLY + 2);
    rd(2'd2, v); check("R2", "status read bits clock+sync", v, 8'h03);
    rd(2'd1, v); check("R2", "clear address reads enables", v, 8'h03);
  endtask

  task automatic t_guard1();
    logic [7:0] v;
    wr(2'd0, 8'h04);
    rd(2'd0, v); check("R2", "disp enable set", v, 8'h07);
    tick(5);  check("R5", "disp waits for frame", disp_o, 0);
    frame();  check("R5", "disp on sampling edge", disp_o, 0);
    tick(1);  check("R5", "disp after guard 1", disp_o, 1);
    wr(2'd1, 8'h04);
    tick(DOFF - 1); check("R9", "disp before off delay", disp_o, 1);
    tick(1);        check("R9", "disp off", disp_o, 0);
    check("R9", "sync stays on", sync_run_o, 1);
  endtask

  task automatic t_guard2();
    logic [7:0] v;
    wr(2'd3, 8'h02);
    rd(2'd3, v); check("R6", "guard readback", v, 2);
    wr(2'd0, 8'h04);
    frame();  tick(3); check("R5", "disp after 1 of 2 frames", disp_o, 0);
    frame();  check("R5", "disp on second sampling edge", disp_o, 0);
    tick(1);  check("R5", "disp after guard 2", disp_o, 1);
  endtask

  task automatic t_sync_cascade();
    logic [7:0] v;
    wr(2'd1, 8'h02);
    rd(2'd0, v); check("R7", "sync clear drops disp enable", v, 8'h01);
    tick(DOFF);
    check("R7", "disp off first", disp_o, 0);
    check("R7", "sync still on", sync_run_o, 1);
    tick(DLY - 1); check("R7", "sync before its delay", sync_run_o, 1);
    tick(1);       check("R7", "sync off", sync_run_o, 0);
  endtask

  task automatic t_guard0();
    wr(2'd0, 8'h02);
    tick(DLY);
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h04);
    check("R5", "guard 0 not on enable edge", disp_o, 0);
    tick(1);
    check("R5", "guard 0 disp next cycle", disp_o, 1);
  endtask

  task automatic t_clock_cascade();
    logic [7:0] v;
    wr(2'd1, 8'h01);
    rd(2'd0, v); check("R8", "clock clear drops all", v, 0);
    tick(DOFF + DLY + DLY - 1);
    rd(2'd2, v); check("R8", "clock held until sync off", v, 8'h01);
    tick(1);
    rd(2'd2, v); check("R8", "clock off last", v, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    tick(2);
    t_reset();
    t_dependency();
    t_pwm();
    t_clock_sync();
    t_zero_writes();
    t_guard1();
    t_guard2();
    t_sync_cascade();
    t_guard0();
    t_clock_cascade();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule